// File: doc/BRIEF.md
# Comparator Output Qualifier

This block cleans up the single-bit decision of an analog comparator in the digital domain. The raw bit is optionally inverted and registered once. It then passes through a glitch qualifier that has five behaviours: straight pass-through, change at once and then blank, change only after a hold time, hold time on falling changes only, and hold time on rising changes only. The hold time is a 9-bit base count of clock cycles scaled by a power of two from 1 to 128.

The qualified level is watched for rising and falling transitions. Each transition sets its own sticky flag, and a flag is cleared by writing 1 to it. Per-edge enables route the flags to one interrupt line and to two DMA request lines. Software reaches the block through a plain single-cycle register write port and a combinational read port. No data stream enters or leaves the block, so it has no valid/ready handshake and no back-pressure. Every pin is a plain control or status signal.

The register map, with one register per address, is as follows:
- Address 0 is the control register: qualifier code in bits [2:0], force-bypass in bit 3, invert in bit 4, length scale in bits [7:5].
- Address 1 is the base length in bits [8:0].
- Address 2 holds the edge flags: rise in bit 0, fall in bit 1.
- Address 3 holds the interrupt enables, with the same bit positions as the flags.
- Address 4 holds the DMA enables, with the same bit positions as the flags.
- Addresses 5 to 7 read as zero.

Top module: `cmp_qualifier`

## Requirements
- R1: After reset, every register reads 0, and `cmp_out`, `irq`, `dma_rise` and `dma_fall` are 0.
- R2: Registers keep their written values and read back through `rd_data` as given in the map above. A write to address 2 clears each flag whose data bit is 1 and leaves the other flags unchanged.
- R3: When bit 3 of the control register is 1, or the qualifier code is 000, `cmp_out` follows the polarity-adjusted input two cycles after the input changes. This holds for every pulse, including one-cycle pulses.
- R4: Qualifier codes 001, 010 and 011 behave exactly like code 000.
- R5: When the invert bit is 1, the qualifier sees the complement of `cmp_raw`. Toggling the invert bit with the input held steady moves `cmp_out` three cycles after the write cycle.
- R6: With code 101 and hold length L, `cmp_out` takes a new level only after the input has held that level for L consecutive samples. The change appears 1+L cycles after the input change. A reversal before then restarts the count.
- R7: The hold length L is the base length shifted left by the scale field (×1 to ×128). A base length of 0 acts as 1.
- R8: With code 100, the first input change reaches `cmp_out` after two cycles. No further output change occurs until L cycles have passed since that change. After the blanking ends, the current input level is taken.
- R9: With code 110, a rise of the input passes after two cycles. A fall is qualified as in R6, so a low glitch shorter than L is ignored.
- R10: With code 111, a fall passes after two cycles. A rise is qualified as in R6.
- R11: A rise of `cmp_out` sets flag bit 0 one cycle later, and a fall sets flag bit 1. A flag stays set until it is cleared. If a clear and a set arrive in the same cycle, the set wins.
- R12: `irq` is 1 exactly while some flag is set whose interrupt enable bit (address 3, same position) is 1.
- R13: `dma_rise` equals flag bit 0 AND DMA enable bit 0, and `dma_fall` equals flag bit 1 AND DMA enable bit 1. Each request stays asserted until its flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the hold-length unit |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_raw | input | 1 | Raw comparator decision |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 9 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 9 | Combinational read data |
| cmp_out | output | 1 | Qualified comparator level |
| irq | output | 1 | Interrupt request |
| dma_rise | output | 1 | DMA request for rising-edge flag |
| dma_fall | output | 1 | DMA request for falling-edge flag |

## Verification
The embedded properties check the following on every cycle:
- In pass-through, the output equals the previous polarity-adjusted sample.
- The output stays frozen while code 100 is blanking, and while code 101 sees no difference between input and output.
- Under code 110 a rise is taken at once.
- Flags set after output edges and are sticky.
- `irq` and the DMA requests fall only after a register write.

Only the scoreboard scenarios show the following:
- The exact cycle counts for hold lengths, including the scale field and a zero base.
- That short pulses are rejected and counts restart.
- The polarity and write-one-to-clear behaviour through the ports.
- Set-over-clear priority.

// File: rtl/cmpq_pkg.sv
package cmpq_pkg;
  localparam int unsigned BASE_W  = 9;
  localparam int unsigned SCALE_W = 3;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned REG_W   = BASE_W;
  localparam int unsigned CNT_W   = BASE_W + (1 << SCALE_W) - 1;
  localparam int unsigned EDGES   = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_LEN  = 3'd1;
  localparam logic [ADDR_W-1:0] A_FLAG = 3'd2;
  localparam logic [ADDR_W-1:0] A_IRQ  = 3'd3;
  localparam logic [ADDR_W-1:0] A_DMA  = 3'd4;

  typedef struct packed {
    logic [SCALE_W-1:0] scale;
    logic               invert;
    logic               force_byp;
    logic [2:0]         code;
  } ctrl_t;

  typedef enum logic [2:0] {
    Q_PASS, Q_IMM, Q_AFTER, Q_LO, Q_HI
  } qual_e;
endpackage

// File: rtl/cmpq_regs.sv
module cmpq_regs
  import cmpq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  output ctrl_t             ctrl,
  output logic [BASE_W-1:0] base_len,
  output logic [EDGES-1:0]  irq_en,
  output logic [EDGES-1:0]  dma_en,
  output logic [EDGES-1:0]  flag_clr
);
  localparam int unsigned CTRL_W = $bits(ctrl_t);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      base_len <= '0;
      irq_en   <= '0;
      dma_en   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL:  ctrl     <= ctrl_t'(wr_data[CTRL_W-1:0]);
        A_LEN:   base_len <= wr_data[BASE_W-1:0];
        A_IRQ:   irq_en   <= wr_data[EDGES-1:0];
        A_DMA:   dma_en   <= wr_data[EDGES-1:0];
        default: ;
      endcase
    end
  end

  assign flag_clr = (wr_en && wr_addr == A_FLAG) ? wr_data[EDGES-1:0] : '0;
endmodule

// File: rtl/cmpq_filter.sv
module cmpq_filter
  import cmpq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raw,
  input  ctrl_t             ctrl,
  input  logic [BASE_W-1:0] base_len,
  output logic              filt
);
  logic             pol_q;
  logic             out_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] hold_len;
  logic [CNT_W:0]   cnt_inc;
  logic             differs, reached, slow;
  qual_e            qual;

  always_comb begin
    if (ctrl.force_byp || !ctrl.code[2]) qual = Q_PASS;
    else begin
      case (ctrl.code[1:0])
        2'd0:    qual = Q_IMM;
        2'd1:    qual = Q_AFTER;
        2'd2:    qual = Q_LO;
        default: qual = Q_HI;
      endcase
    end
  end

  assign hold_len = CNT_W'((base_len == '0) ? BASE_W'(1) : base_len) << ctrl.scale;
  assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
  assign reached  = cnt_inc >= {1'b0, hold_len};
  assign differs  = pol_q != filt;
  assign slow     = (qual == Q_AFTER) || (qual == Q_LO && !pol_q) ||
                    (qual == Q_HI && pol_q);

  always_comb begin
    out_d = filt;
    cnt_d = cnt_q;
    case (qual)
      Q_PASS: begin
        out_d = pol_q;
        cnt_d = '0;
      end
      Q_IMM: begin
        if (cnt_q != '0) begin
          cnt_d = reached ? '0 : cnt_inc[CNT_W-1:0];
        end else if (differs) begin
          out_d = pol_q;
          cnt_d = (hold_len > CNT_W'(1)) ? CNT_W'(1) : '0;
        end
      end
      default: begin
        if (!differs) begin
          cnt_d = '0;
        end else if (!slow || reached) begin
          out_d = pol_q;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_inc[CNT_W-1:0];
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= 1'b0;
      filt  <= 1'b0;
      cnt_q <= '0;
    end else begin
      pol_q <= raw ^ ctrl.invert;
      filt  <= out_d;
      cnt_q <= cnt_d;
    end
  end

  // R3
  pass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    qual == Q_PASS |=> filt == $past(pol_q));
  // R6
  after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qual == Q_AFTER && pol_q == filt) |=> $stable(filt));
  // R8
  imm_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qual == Q_IMM && cnt_q != '0) |=> $stable(filt));
  // R9
  lo_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qual == Q_LO && pol_q && !filt) |=> filt);
endmodule

// File: rtl/cmpq_edges.sv
module cmpq_edges
  import cmpq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             filt,
  input  logic [EDGES-1:0] clr,
  output logic [EDGES-1:0] flags
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= filt;
  end

  for (genvar g = 0; g < EDGES; g++) begin : g_edge
    logic ev;
    logic flag_q;
    if (g == 0) begin : g_rise
      assign ev = filt & ~prev_q;
    end else begin : g_fall
      assign ev = ~filt & prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q <= 1'b0;
      else if (ev)     flag_q <= 1'b1;
      else if (clr[g]) flag_q <= 1'b0;
    end
    assign flags[g] = flag_q;

    // R11
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[g] && !clr[g]) |=> flags[g]);
  end

  // R11
  rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(filt) |=> flags[0]);
  // R11
  fall_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(filt) |=> flags[1]);
endmodule

// File: rtl/cmp_qualifier.sv
module cmp_qualifier
  import cmpq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_raw,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic              cmp_out,
  output logic              irq,
  output logic              dma_rise,
  output logic              dma_fall
);
  ctrl_t             ctrl;
  logic [BASE_W-1:0] base_len;
  logic [EDGES-1:0]  irq_en, dma_en, flag_clr, flags;

  cmpq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl(ctrl), .base_len(base_len),
    .irq_en(irq_en), .dma_en(dma_en), .flag_clr(flag_clr)
  );

  cmpq_filter u_filter (
    .clk(clk), .rst_n(rst_n), .raw(cmp_raw), .ctrl(ctrl),
    .base_len(base_len), .filt(cmp_out)
  );

  cmpq_edges u_edges (
    .clk(clk), .rst_n(rst_n), .filt(cmp_out), .clr(flag_clr), .flags(flags)
  );

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = REG_W'(ctrl);
      A_LEN:   rd_data = REG_W'(base_len);
      A_FLAG:  rd_data = REG_W'(flags);
      A_IRQ:   rd_data = REG_W'(irq_en);
      A_DMA:   rd_data = REG_W'(dma_en);
      default: rd_data = '0;
    endcase
  end

  assign irq      = |(flags & irq_en);
  assign dma_rise = flags[0] & dma_en[0];
  assign dma_fall = flags[1] & dma_en[1];

  // R12
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_en));
  // R13
  dma_rise_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dma_rise) |-> $past(wr_en));
  // R13
  dma_fall_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dma_fall) |-> $past(wr_en));
endmodule

// File: tb/tb_cmp_qualifier.sv
`timescale 1ns/1ps
module tb_cmp_qualifier;
  import cmpq_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmp_raw = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [REG_W-1:0]  wr_data = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [REG_W-1:0]  rd_data;
  logic              cmp_out, irq, dma_rise, dma_fall;

  cmp_qualifier dut (
    .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .cmp_out(cmp_out), .irq(irq),
    .dma_rise(dma_rise), .dma_fall(dma_fall)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    logic  lvl;
    string req;
  } exp_t;
  exp_t sbq[$];

  task automatic check(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, int d);
    wr_en = 1'b1; wr_addr = a; wr_data = REG_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(logic [ADDR_W-1:0] a, int expv, string req);
    rd_addr = a;
    #1;
    check(req, int'(rd_data), expv);
  endtask

  function automatic int cw(int code, int byp, int inv, int scale);
    return (scale << 5) | (inv << 4) | (byp << 3) | code;
  endfunction

  task automatic expect_at(int d, logic lvl, string req);
    exp_t e;
    e.at = cyc + d; e.lvl = lvl; e.req = req;
    sbq.push_back(e);
  endtask

  task automatic expect_done(string req);
    idle(2);
    check({req, " pending transitions"}, sbq.size(), 0);
    sbq.delete();
  endtask

  // Monitor: every output transition must match the next queued item.
  logic last_out = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (cmp_out !== last_out) begin
        checks++;
        if (sbq.size() == 0) begin
          fails++;
          $display("FAIL unexpected transition actual=%0d@%0d expected=none",
                   cmp_out, cyc);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          if (e.at != cyc || e.lvl !== cmp_out) begin
            fails++;
            $display("FAIL %s actual=%0d@%0d expected=%0d@%0d",
                     e.req, cmp_out, cyc, e.lvl, e.at);
          end
        end
      end
      last_out = cmp_out;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    check("R1 cmp_out", cmp_out, 0);
    check("R1 irq", irq, 0);
    check("R1 dma", {dma_rise, dma_fall}, 0);
    for (int a = 0; a < 8; a++) rd_chk(ADDR_W'(a), 0, "R1 reg");

    // R2 readback
    wr(A_IRQ, 2); wr(A_DMA, 1); wr(A_LEN, 9'h1A5);
    rd_chk(A_IRQ, 2, "R2 irq_en"); rd_chk(A_DMA, 1, "R2 dma_en");
    rd_chk(A_LEN, 9'h1A5, "R2 len");
    wr(A_IRQ, 0); wr(A_DMA, 0); wr(A_LEN, 0);

    // R3 pass-through, including a one-cycle pulse
    cmp_raw = 1; expect_at(2, 1, "R3"); idle(4);
    cmp_raw = 0; expect_at(2, 0, "R3"); idle(4);
    cmp_raw = 1; expect_at(2, 1, "R3"); idle(1);
    cmp_raw = 0; expect_at(2, 0, "R3"); idle(4);
    expect_done("R3");

    // R2 / R11 flags and write-one-to-clear
    rd_chk(A_FLAG, 3, "R11 both flags");
    wr(A_FLAG, 1); rd_chk(A_FLAG, 2, "R2 clear rise only");
    wr(A_FLAG, 2); rd_chk(A_FLAG, 0, "R2 clear fall");

    // R4 unlisted codes pass glitches; R3 force-bypass overrides code 101
    wr(A_LEN, 5);
    for (int c = 1; c < 4; c++) begin
      wr(A_CTRL, c);
      rd_chk(A_CTRL, c, "R2 ctrl");
      cmp_raw = 1; expect_at(2, 1, "R4"); idle(1);
      cmp_raw = 0; expect_at(2, 0, "R4"); idle(4);
    end
    wr(A_CTRL, cw(5, 1, 0, 0));
    cmp_raw = 1; expect_at(2, 1, "R3 force"); idle(1);
    cmp_raw = 0; expect_at(2, 0, "R3 force"); idle(4);
    expect_done("R4");

    // R6 change after hold, L=4
    wr(A_LEN, 4); wr(A_CTRL, 5);
    cmp_raw = 1; idle(3); cmp_raw = 0; idle(8);
    cmp_raw = 1; expect_at(5, 1, "R6"); idle(8);
    cmp_raw = 0; idle(3); cmp_raw = 1; idle(1);
    cmp_raw = 0; expect_at(5, 0, "R6 restart"); idle(8);
    expect_done("R6");

    // R7 scaled length: 3<<2 = 12; zero base acts as 1
    wr(A_LEN, 3); wr(A_CTRL, cw(5, 0, 0, 2));
    cmp_raw = 1; idle(11); cmp_raw = 0; idle(16);
    cmp_raw = 1; expect_at(13, 1, "R7"); idle(16);
    wr(A_LEN, 0); wr(A_CTRL, 5);
    cmp_raw = 0; expect_at(2, 0, "R7 zero"); idle(4);
    expect_done("R7");

    // R8 immediate then blanking, L=6
    wr(A_LEN, 6); wr(A_CTRL, 4);
    cmp_raw = 1; expect_at(2, 1, "R8"); idle(1);
    cmp_raw = 0; expect_at(7, 0, "R8 blank"); idle(16);
    cmp_raw = 1; expect_at(2, 1, "R8 again"); idle(10);
    cmp_raw = 0; expect_at(2, 0, "R8 after"); idle(10);
    expect_done("R8");

    // R9 stable-low, L=5
    wr(A_LEN, 5); wr(A_CTRL, 6);
    cmp_raw = 1; expect_at(2, 1, "R9 rise"); idle(6);
    cmp_raw = 0; idle(2); cmp_raw = 1; idle(8);
    cmp_raw = 0; expect_at(6, 0, "R9 fall"); idle(8);
    expect_done("R9");

    // R10 stable-high
    wr(A_CTRL, 7);
    cmp_raw = 1; expect_at(6, 1, "R10 rise"); idle(8);
    cmp_raw = 0; expect_at(2, 0, "R10 fall"); idle(1);
    cmp_raw = 1; expect_at(6, 1, "R10 requal"); idle(8);
    cmp_raw = 0; expect_at(2, 0, "R10 fall"); idle(4);
    expect_done("R10");

    // R5 polarity
    expect_at(3, 1, "R5 invert on"); wr(A_CTRL, cw(0, 0, 1, 0)); idle(3);
    cmp_raw = 1; expect_at(2, 0, "R5"); idle(4);
    expect_at(3, 1, "R5 invert off"); wr(A_CTRL, 0); idle(3);
    cmp_raw = 0; expect_at(2, 0, "R5"); idle(4);
    expect_done("R5");

    // R12 / R13 request routing
    wr(A_FLAG, 3);
    rd_chk(A_FLAG, 0, "R2 cleared");
    wr(A_IRQ, 1); wr(A_DMA, 2);
    check("R12 idle", irq, 0);
    check("R13 idle", {dma_rise, dma_fall}, 0);
    cmp_raw = 1; expect_at(2, 1, "R12"); idle(4);
    check("R12 rise irq", irq, 1);
    check("R13 rise dma disabled", dma_rise, 0);
    check("R13 fall dma none", dma_fall, 0);
    cmp_raw = 0; expect_at(2, 0, "R13"); idle(4);
    check("R13 fall dma", dma_fall, 1);
    idle(3);
    check("R13 dma held", dma_fall, 1);
    wr(A_FLAG, 2);
    check("R13 dma cleared", dma_fall, 0);
    check("R12 irq kept", irq, 1);
    wr(A_FLAG, 1);
    check("R12 irq cleared", irq, 0);
    wr(A_IRQ, 2);
    check("R12 fall enable, no flag", irq, 0);
    wr(A_IRQ, 1); wr(A_DMA, 1);

    // R11 set beats simultaneous clear
    cmp_raw = 1; expect_at(2, 1, "R11"); idle(2);
    wr(A_FLAG, 1);
    rd_chk(A_FLAG, 1, "R11 set wins");
    check("R13 rise dma", dma_rise, 1);
    wr(A_FLAG, 1);
    rd_chk(A_FLAG, 0, "R11 clear");
    check("R13 rise dma drop", dma_rise, 0);
    expect_done("R11");

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule